// File: doc/BRIEF.md
# Descriptor Ring Channel Registers

This block keeps the index state of one data-mover channel whose two circular queues live in host memory. The host posts work into a request queue and drains results from a response queue. The device side takes request elements and pushes response elements. Four index registers sit on a small word-addressed register bus. The host owns the request tail and the response head. The device owns the request head and the response tail.

Both queues live in one contiguous host-memory chunk. Request elements are packed from the start of the chunk, and the response elements fill the last bytes of the chunk. The block turns the live indexes into byte addresses for the element the device should fetch next and for the slot it should write next. It also raises a one-cycle message-signalled interrupt pulse when the response queue stops being empty. A completing request that carries a force flag also raises the pulse, provided forcing is enabled.

Top module: `ring_chan_regs`

## Requirements
- R1: After reset all four indexes read zero, `req_avail` is 0, `rsp_full` is 0 and `msi_pulse` is 0.
- R2: `reg_word` selects the register: 0 request head, 1 request tail, 2 response head, 3 response tail (byte offsets 0x0, 0x4, 0x8, 0xC). `reg_rdata` shows the live value of the selected index in the same cycle.
- R3: A write to word 1 or word 2 stores `reg_wdata` modulo the depth of that queue. The stored value is readable after the write edge.
- R4: A write to word 0 or word 3 is ignored. The index keeps its value.
- R5: `req_avail` is 1 exactly when request head differs from request tail. A `req_take` while `req_avail` is 1 advances the head by one. A `req_take` while `req_avail` is 0 is ignored.
- R6: `rsp_full` is 1 when tail+1 modulo the depth equals the response head. A `rsp_push` while `rsp_full` is 0 advances the tail by one. A `rsp_push` while `rsp_full` is 1 is ignored and raises no interrupt.
- R7: Each queue holds 2**depth_log2 slots, and both indexes of a queue wrap from depth-1 to 0.
- R8: `req_addr` equals `chunk_base + req_head*REQ_BYTES`.
- R9: `rsp_addr` equals `chunk_base + chunk_len - rsp_depth*RSP_BYTES + rsp_tail*RSP_BYTES`.
- R10: In the cycle after an accepted push into an empty response queue (head equal to tail), `msi_pulse` is 1 for exactly one cycle. An accepted push into a non-empty queue raises no pulse unless R11 applies.
- R11: An accepted push with `rsp_force` set and `force_en` set pulses `msi_pulse` in the next cycle whatever the queue state. With `force_en` clear, the force flag has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_depth_log2 | input | LOG_W | log2 of request queue depth (static) |
| rsp_depth_log2 | input | LOG_W | log2 of response queue depth (static) |
| chunk_base | input | ADDR_W | Byte address of the shared chunk |
| chunk_len | input | ADDR_W | Byte length of the shared chunk |
| force_en | input | 1 | Lets the force flag raise interrupts |
| reg_we | input | 1 | Register write strobe |
| reg_word | input | 2 | Register word select (byte offset bits 3:2) |
| reg_wdata | input | IDX_W | Register write data |
| reg_rdata | output | IDX_W | Register read data, combinational |
| req_avail | output | 1 | Request queue holds an element |
| req_addr | output | ADDR_W | Byte address of the element at request head |
| req_take | input | 1 | Device consumes the request element at head |
| rsp_full | output | 1 | Response queue cannot take another element |
| rsp_addr | output | ADDR_W | Byte address of the slot at response tail |
| rsp_push | input | 1 | Device produces a response element |
| rsp_force | input | 1 | Force flag of the request completing with this push |
| msi_pulse | output | 1 | One-cycle interrupt request |

## Verification
The bench fills the response queue to its one-slot-short limit and pushes once more. A design with an off-by-one full test would move the tail onto the head and make a full queue look empty. It also takes from an empty request queue; a head that moved anyway would skip past the tail. It writes tail values above the depth and runs the head all the way around, so a missing modulo shows up as an out-of-range index or a wrong address. The interrupt checks push into a queue that has just been drained and into one that already holds entries, and use the force flag both with and without `force_en`. A design that pulsed on every push, or that ignored the enable, would show the wrong `msi_pulse`.

// File: rtl/ring_pkg.sv
package ring_pkg;
  // Register slots on the word-addressed bus; slot order fixes byte offsets.
  typedef enum logic [1:0] {
    SLOT_REQ_HEAD = 2'd0,
    SLOT_REQ_TAIL = 2'd1,
    SLOT_RSP_HEAD = 2'd2,
    SLOT_RSP_TAIL = 2'd3
  } slot_e;
endpackage

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int IDX_W      = 32,
  parameter int LOG_W      = $clog2(IDX_W + 1),
  parameter bit HOST_OWNED = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOG_W-1:0] depth_log2,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_wdata,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] mask
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [IDX_W-1:0] idx_d;
  logic             idx_en;

  assign mask = (ONE << depth_log2) - ONE;

  generate
    if (HOST_OWNED) begin : g_host
      always_comb begin
        idx_en = host_we;
        idx_d  = host_wdata & mask;
      end
    end else begin : g_dev
      always_comb begin
        idx_en = adv;
        idx_d  = (idx + ONE) & mask;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx <= '0;
    else if (idx_en) idx <= idx_d;
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (idx & ~mask) == '0); // R7

  generate
    if (!HOST_OWNED) begin : g_chk_dev
      AST_DEV_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(idx)); // R4
    end
  endgenerate
endmodule

// File: rtl/ring_irq.sv
module ring_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic push_ok,
  input  logic was_empty,
  input  logic force_flag,
  input  logic force_en,
  output logic msi_pulse
);
  logic msi_d;

  always_comb begin
    msi_d = push_ok && (was_empty || (force_flag && force_en));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msi_pulse <= 1'b0;
    else        msi_pulse <= msi_d;
  end

  AST_MSI_NEEDS_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> $past(push_ok)); // R10
  AST_MSI_NO_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !was_empty && !force_en) |=> !msi_pulse); // R11
endmodule

// File: rtl/ring_addr.sv
module ring_addr #(
  parameter int IDX_W     = 32,
  parameter int ADDR_W    = 64,
  parameter int REQ_BYTES = 64,
  parameter int RSP_BYTES = 4
) (
  input  logic [ADDR_W-1:0] chunk_base,
  input  logic [ADDR_W-1:0] chunk_len,
  input  logic [IDX_W-1:0]  req_head,
  input  logic [IDX_W-1:0]  rsp_tail,
  input  logic [IDX_W-1:0]  rsp_mask,
  output logic [ADDR_W-1:0] req_addr,
  output logic [ADDR_W-1:0] rsp_addr
);
  localparam int REQ_SH = $clog2(REQ_BYTES);
  localparam int RSP_SH = $clog2(RSP_BYTES);

  logic [ADDR_W-1:0] rsp_span;
  logic [ADDR_W-1:0] rsp_base;

  always_comb begin
    rsp_span = (ADDR_W'(rsp_mask) + ADDR_W'(1)) << RSP_SH;
    rsp_base = chunk_base + chunk_len - rsp_span;
    req_addr = chunk_base + (ADDR_W'(req_head) << REQ_SH);
    rsp_addr = rsp_base + (ADDR_W'(rsp_tail) << RSP_SH);
  end
endmodule

// File: rtl/ring_chan_regs.sv
module ring_chan_regs
  import ring_pkg::*;
#(
  parameter int IDX_W     = 32,
  parameter int ADDR_W    = 64,
  parameter int REQ_BYTES = 64,
  parameter int RSP_BYTES = 4,
  parameter int LOG_W     = $clog2(IDX_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOG_W-1:0]  req_depth_log2,
  input  logic [LOG_W-1:0]  rsp_depth_log2,
  input  logic [ADDR_W-1:0] chunk_base,
  input  logic [ADDR_W-1:0] chunk_len,
  input  logic              force_en,
  input  logic              reg_we,
  input  logic [1:0]        reg_word,
  input  logic [IDX_W-1:0]  reg_wdata,
  output logic [IDX_W-1:0]  reg_rdata,
  output logic              req_avail,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              req_take,
  output logic              rsp_full,
  output logic [ADDR_W-1:0] rsp_addr,
  input  logic              rsp_push,
  input  logic              rsp_force,
  output logic              msi_pulse
);
  logic [IDX_W-1:0] req_head, req_tail, rsp_head, rsp_tail;
  logic [IDX_W-1:0] req_mask, req_mask_t, rsp_mask, rsp_mask_t;
  logic             take_ok, push_ok, rsp_empty;
  logic             wr_req_tail, wr_rsp_head;
  slot_e            slot;

  always_comb begin
    slot        = slot_e'(reg_word);
    wr_req_tail = reg_we && (slot == SLOT_REQ_TAIL);
    wr_rsp_head = reg_we && (slot == SLOT_RSP_HEAD);
    req_avail   = (req_head != req_tail);
    rsp_empty   = (rsp_head == rsp_tail);
    rsp_full    = (((rsp_tail + IDX_W'(1)) & rsp_mask) == rsp_head);
    take_ok     = req_take && req_avail;
    push_ok     = rsp_push && !rsp_full;
    unique case (slot)
      SLOT_REQ_HEAD: reg_rdata = req_head;
      SLOT_REQ_TAIL: reg_rdata = req_tail;
      SLOT_RSP_HEAD: reg_rdata = rsp_head;
      default:       reg_rdata = rsp_tail;
    endcase
  end

  ring_ptr #(.IDX_W(IDX_W), .LOG_W(LOG_W), .HOST_OWNED(1'b0)) u_req_head (
    .clk(clk), .rst_n(rst_n), .depth_log2(req_depth_log2),
    .host_we(1'b0), .host_wdata(reg_wdata), .adv(take_ok),
    .idx(req_head), .mask(req_mask));

  ring_ptr #(.IDX_W(IDX_W), .LOG_W(LOG_W), .HOST_OWNED(1'b1)) u_req_tail (
    .clk(clk), .rst_n(rst_n), .depth_log2(req_depth_log2),
    .host_we(wr_req_tail), .host_wdata(reg_wdata), .adv(1'b0),
    .idx(req_tail), .mask(req_mask_t));

  ring_ptr #(.IDX_W(IDX_W), .LOG_W(LOG_W), .HOST_OWNED(1'b1)) u_rsp_head (
    .clk(clk), .rst_n(rst_n), .depth_log2(rsp_depth_log2),
    .host_we(wr_rsp_head), .host_wdata(reg_wdata), .adv(1'b0),
    .idx(rsp_head), .mask(rsp_mask_t));

  ring_ptr #(.IDX_W(IDX_W), .LOG_W(LOG_W), .HOST_OWNED(1'b0)) u_rsp_tail (
    .clk(clk), .rst_n(rst_n), .depth_log2(rsp_depth_log2),
    .host_we(1'b0), .host_wdata(reg_wdata), .adv(push_ok),
    .idx(rsp_tail), .mask(rsp_mask));

  ring_addr #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .REQ_BYTES(REQ_BYTES),
              .RSP_BYTES(RSP_BYTES)) u_addr (
    .chunk_base(chunk_base), .chunk_len(chunk_len),
    .req_head(req_head), .rsp_tail(rsp_tail), .rsp_mask(rsp_mask),
    .req_addr(req_addr), .rsp_addr(rsp_addr));

  ring_irq u_irq (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .was_empty(rsp_empty),
    .force_flag(rsp_force), .force_en(force_en), .msi_pulse(msi_pulse));

  AST_MASKS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mask == req_mask_t) && (rsp_mask == rsp_mask_t)); // R7
  AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_take && !req_avail && !wr_req_tail) |=> !req_avail); // R5
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_push && rsp_full && !wr_rsp_head) |=> (rsp_full && !msi_pulse)); // R6
  AST_EMPTY_PUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_push && rsp_empty && !rsp_full) |=> msi_pulse); // R10
  AST_RO_HEAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && slot == SLOT_REQ_HEAD && !req_take) |=> $stable(req_head)); // R4
endmodule

// File: tb/ring_chan_regs_test.sv
module ring_chan_regs_test;
  localparam int IDX_W  = 32;
  localparam int ADDR_W = 64;
  localparam int LOG_W  = $clog2(IDX_W + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic [LOG_W-1:0]  req_depth_log2, rsp_depth_log2;
  logic [ADDR_W-1:0] chunk_base, chunk_len;
  logic              force_en, reg_we, req_take, rsp_push, rsp_force;
  logic [1:0]        reg_word;
  logic [IDX_W-1:0]  reg_wdata, reg_rdata;
  logic              req_avail, rsp_full, msi_pulse;
  logic [ADDR_W-1:0] req_addr, rsp_addr;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  ring_chan_regs uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] w, output logic [IDX_W-1:0] v);
    @(negedge clk); reg_word = w; #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] w, input logic [IDX_W-1:0] v);
    @(negedge clk); reg_word = w; reg_wdata = v; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic take1();
    @(negedge clk); req_take = 1'b1;
    @(negedge clk); req_take = 1'b0;
  endtask

  // push once, return msi value seen right after the accepting edge
  task automatic push1(input logic frc, output logic m);
    @(negedge clk); rsp_push = 1'b1; rsp_force = frc;
    @(posedge clk); #1 m = msi_pulse;
    @(negedge clk); rsp_push = 1'b0; rsp_force = 1'b0;
  endtask

  task automatic t_reset();
    logic [IDX_W-1:0] v;
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), v); chk("R1 index reset", v, 0);
    end
    chk("R1 req_avail", req_avail, 0);
    chk("R1 rsp_full", rsp_full, 0);
    chk("R1 msi", msi_pulse, 0);
  endtask

  task automatic t_req();
    logic [IDX_W-1:0] v;
    wr(2'd1, 32'd10);            // depth 8 -> stores 2
    rd(2'd1, v); chk("R3 req tail modulo", v, 2);
    chk("R5 avail", req_avail, 1);
    chk("R8 addr head0", req_addr, 64'h1000);
    take1(); #1 chk("R8 addr head1", req_addr, 64'h1040);
    take1(); rd(2'd0, v); chk("R5 head advance", v, 2);
    chk("R5 empty", req_avail, 0);
    take1(); rd(2'd0, v); chk("R5 take when empty", v, 2);
    wr(2'd0, 32'd5); rd(2'd0, v); chk("R4 head write ignored", v, 2);
    wr(2'd1, 32'd1);
    for (int i = 0; i < 7; i++) take1();
    rd(2'd0, v); chk("R7 head wrap", v, 1);
    chk("R2 offset0 live", v, 1);
    chk("R8 addr after wrap", req_addr, 64'h1040);
  endtask

  task automatic t_rsp();
    logic [IDX_W-1:0] v;
    logic m;
    chk("R9 addr tail0", rsp_addr, 64'h13F0);
    push1(1'b0, m); chk("R10 pulse on empty", m, 1);
    @(posedge clk); #1 chk("R10 one cycle", msi_pulse, 0);
    push1(1'b0, m); chk("R10 no pulse nonempty", m, 0);
    push1(1'b0, m);
    chk("R6 full", rsp_full, 1);
    push1(1'b0, m); chk("R6 no pulse when full", m, 0);
    rd(2'd3, v); chk("R6 push when full ignored", v, 3);
    chk("R9 addr tail3", rsp_addr, 64'h13FC);
    wr(2'd3, 32'd0); rd(2'd3, v); chk("R4 tail write ignored", v, 3);
    wr(2'd2, 32'd7); rd(2'd2, v); chk("R3 rsp head modulo", v, 3);
    push1(1'b0, m); chk("R10 pulse after drain", m, 1);
    rd(2'd3, v); chk("R7 tail wrap", v, 0);
    force_en = 1'b1;
    push1(1'b1, m); chk("R11 forced pulse", m, 1);
    force_en = 1'b0;
    push1(1'b1, m); chk("R11 force disabled", m, 0);
    chk("R6 full again", rsp_full, 1);
  endtask

  initial begin
    #150000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_depth_log2 = 3; rsp_depth_log2 = 2;
    chunk_base = 64'h1000; chunk_len = 64'h400; force_en = 1'b0;
    reg_we = 1'b0; reg_word = 2'd0; reg_wdata = '0;
    req_take = 1'b0; rsp_push = 1'b0; rsp_force = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_req();
    t_rsp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule